// File: doc/BRIEF.md
# Serial EEPROM Bridge Driven by a Software Port Register

This block lets a processor talk to an internal 128-word, 16-bit serial EEPROM model by writing bit patterns to a single byte-wide port register. Software raises and lowers chip select, the serial clock and the data-in bit, then reads the data-out bit back. The block detects each clock and select edge by comparing a new write with the value the port held before. A shift state machine then collects a start bit, a command and an address, and carries out the operation on the storage array.

The port is hidden until software has written two unlock values to two other address regions. A read of the port while it is locked returns 0xFF, and a write to it while it is locked is discarded. A separate read-only peek port exposes any word of the storage array, so the surrounding logic can observe the non-volatile contents.

Top module: `mw_eeprom_bridge`

## Requirements
- R1: The port is open only when 0x0A has been written to a region with address bits [15:13]=0 and 0x40 has been written to a region with [15:13]=2. Any other value written to region 0 closes both enables. Any other value written to region 2 closes the second enable. While the port is closed, port writes are discarded and reads return 0xFF. The port is decoded where (address & 0xE0F0) == 0xA080. Every other read returns 0xFF.
- R2: Port bit 7 is chip select, bit 6 is the serial clock, bit 1 is data-in and bit 0 is data-out. A read returns the written bits 7..2 and the data-out bit as the block drives it. When nothing drives data-out it reads 1.
- R3: A rising edge of chip select returns the state machine to idle, which abandons any partial command.
- R4: In idle, a rising clock with data-in 1 is the start bit. A rising clock with data-in 0 is ignored.
- R5: The ten bits after the start bit are shifted in MSB first. Bits [9:8] are the opcode: 01 write, 10 read, 11 erase, 00 special. For opcode 00, bits [7:6] select 00 disable-writes, 01 write-all, 10 erase-all and 11 enable-writes. Bits [6:0] are the word address.
- R6: Enable-writes sets a write-allowed latch and disable-writes clears it. Write, erase, write-all and erase-all leave the storage unchanged while the latch is clear.
- R7: Write and write-all take 16 more data bits MSB first and commit on the 16th rising clock, to one word or to all 128 words.
- R8: Erase sets the addressed word to 0xFFFF. Erase-all sets every word to 0xFFFF.
- R9: On the rising clock that completes a read command, data-out becomes 0 as a dummy bit. Each of the next 16 rising clocks presents one bit of the word, MSB first. After the 16th bit the machine is idle.
- R10: While chip select is high, a falling clock edge leaves data-out at its previous value.
- R11: After reset every word is 0xFFFF, the write-allowed latch is clear and the port reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Processor write strobe for one cycle |
| cpu_addr | input | 16 | Processor address for writes and reads |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Port read-back, or 0xFF |
| peek_addr | input | ADDR_W | Word index to observe in storage |
| peek_data | output | DATA_W | Storage word at peek_addr |

## Verification
The bench builds the block with its defaults: a 7-bit word address and 16-bit words. With these values the highest address 0x7F, a full 10-bit command frame and the 16-bit data frame are all reachable. Write-all and erase-all then cover all 128 words, so a sweep reaches every array entry. The bench checks the serial read-out bit by bit, and it checks the storage through the peek port after commands issued with the write latch both set and clear.

// File: rtl/mw_pkg.sv
// Shared definitions for the serial EEPROM bridge.
// Assumes an 8-bit port register with fixed bit roles.
package mw_pkg;
    localparam int BIT_CS = 7;
    localparam int BIT_CK = 6;
    localparam int BIT_DI = 1;
    localparam int BIT_DO = 0;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_DOUT,
        ST_EWDS, ST_WRAL, ST_ERAL, ST_EWEN,
        ST_WRITE, ST_READ, ST_ERASE
    } mw_state_t;

    // Map {opcode, extension} to the state that carries out the command.
    function automatic mw_state_t mw_decode(input logic [3:0] code);
        mw_state_t s;
        case (code[3:2])
            2'b01:   s = ST_WRITE;
            2'b10:   s = ST_READ;
            2'b11:   s = ST_ERASE;
            default: begin
                case (code[1:0])
                    2'b00:   s = ST_EWDS;
                    2'b01:   s = ST_WRAL;
                    2'b10:   s = ST_ERAL;
                    default: s = ST_EWEN;
                endcase
            end
        endcase
        return s;
    endfunction
endpackage

// File: rtl/mw_unlock.sv
// Two-step access gate for the port register.
// Assumes the region index is address bits [15:13] of a processor write.
module mw_unlock (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [2:0] region_i,
    input  logic [7:0] wdata_i,
    output logic       open_o
);
    logic ram_en_q;
    logic key_q;

    // Track the two unlock values written by the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_en_q <= 1'b0;
            key_q    <= 1'b0;
        end else if (we_i) begin
            if (region_i == 3'd0) begin
                if (wdata_i == 8'h0A) begin
                    ram_en_q <= 1'b1;
                end else begin
                    ram_en_q <= 1'b0;
                    key_q    <= 1'b0;
                end
            end else if (region_i == 3'd2) begin
                key_q <= (wdata_i == 8'h40);
            end
        end
    end

    assign open_o = ram_en_q & key_q;
endmodule

// File: rtl/mw_store.sv
// Word storage for the EEPROM model: one addressed write or a fill of all words.
// Assumes the write and fill strobes come already gated by the write latch.
module mw_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              all_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    output logic [DATA_W-1:0] rdata_a_o,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic [DATA_W-1:0] rdata_b_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Each word loads on its own address match or on a fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '1;
            end else if (all_i || (we_i && (waddr_i == ADDR_W'(g)))) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

    AST_FILL_REACHES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        all_i |=> (mem_q[DEPTH-1] == $past(wdata_i)) && (mem_q[0] == $past(wdata_i))); // R7
endmodule

// File: rtl/mw_serial_fsm.sv
// Edge-detecting serial state machine behind the port register.
// Assumes each accepted port write is one strobe and edges are found by
// comparing it with the held port value; data-out floats high unless driven.
module mw_serial_fsm
    import mw_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [7:0]        wval_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              st_we_o,
    output logic              st_all_o,
    output logic [ADDR_W-1:0] st_addr_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic [7:0]        port_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CMD_CNT  = CNT_W'(ADDR_W + 3);
    localparam logic [CNT_W-1:0] DATA_CNT = CNT_W'(DATA_W);

    mw_state_t         st_q, st_n;
    logic [DATA_W-1:0] sr_q, sr_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              wl_q, wl_n;
    logic [7:0]        port_q, port_n;
    logic [7:0]        v;
    logic              clk_rise;

    // Word index seen by the shift register after the current bit enters.
    assign rd_addr_o = {sr_q[ADDR_W-2:0], wval_i[BIT_DI]};

    // Next-state, shift and commit logic for one accepted port write.
    always_comb begin
        st_n      = st_q;
        sr_n      = sr_q;
        cnt_n     = cnt_q;
        addr_n    = addr_q;
        wl_n      = wl_q;
        port_n    = port_q;
        v         = port_q;
        clk_rise  = 1'b0;
        st_we_o   = 1'b0;
        st_all_o  = 1'b0;
        st_addr_o = addr_q;
        st_data_o = '1;
        if (wr_stb_i) begin
            v        = wval_i | 8'h01;
            clk_rise = !port_q[BIT_CK] && v[BIT_CK];
            if (!port_q[BIT_CS] && v[BIT_CS]) begin
                st_n = ST_IDLE;
            end
            if (clk_rise) begin
                if (st_n == ST_CMD || st_n == ST_WRITE || st_n == ST_WRAL) begin
                    sr_n  = {sr_q[DATA_W-2:0], v[BIT_DI]};
                    cnt_n = cnt_q + 1'b1;
                end
                case (st_n)
                    ST_IDLE: begin
                        if (v[BIT_DI]) begin
                            st_n  = ST_CMD;
                            cnt_n = '0;
                            sr_n  = '0;
                        end
                    end
                    ST_CMD: begin
                        if (cnt_n == CMD_CNT) begin
                            st_n   = mw_decode(sr_n[ADDR_W+2:ADDR_W-1]);
                            cnt_n  = '0;
                            addr_n = sr_n[ADDR_W-1:0];
                        end
                    end
                    ST_DOUT: begin
                        v[BIT_DO] = sr_q[DATA_W-1];
                        sr_n      = {sr_q[DATA_W-2:0], 1'b0};
                        cnt_n     = cnt_q - 1'b1;
                        if (cnt_n == '0) begin
                            st_n = ST_IDLE;
                        end
                    end
                    default: ;
                endcase
                case (st_n)
                    ST_EWEN: begin
                        wl_n = 1'b1;
                        st_n = ST_IDLE;
                    end
                    ST_EWDS: begin
                        wl_n = 1'b0;
                        st_n = ST_IDLE;
                    end
                    ST_WRITE: begin
                        if (cnt_n == DATA_CNT) begin
                            st_we_o   = wl_q;
                            st_addr_o = addr_n;
                            st_data_o = sr_n;
                            st_n      = ST_IDLE;
                        end
                    end
                    ST_ERASE: begin
                        st_we_o   = wl_q;
                        st_addr_o = addr_n;
                        st_n      = ST_IDLE;
                    end
                    ST_READ: begin
                        cnt_n     = DATA_CNT;
                        sr_n      = rd_word_i;
                        st_n      = ST_DOUT;
                        v[BIT_DO] = 1'b0;
                    end
                    ST_WRAL: begin
                        if (cnt_n == DATA_CNT) begin
                            st_all_o  = wl_q;
                            st_data_o = sr_n;
                            st_n      = ST_IDLE;
                        end
                    end
                    ST_ERAL: begin
                        st_all_o = wl_q;
                        st_n     = ST_IDLE;
                    end
                    default: ;
                endcase
            end else if (v[BIT_CS] && port_q[BIT_CK] && !v[BIT_CK]) begin
                v[BIT_DO] = port_q[BIT_DO];
            end
            port_n = v;
        end
    end

    // State registers of the serial machine and the port image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sr_q   <= '0;
            cnt_q  <= '0;
            addr_q <= '0;
            wl_q   <= 1'b0;
            port_q <= 8'h01;
        end else begin
            st_q   <= st_n;
            sr_q   <= sr_n;
            cnt_q  <= cnt_n;
            addr_q <= addr_n;
            wl_q   <= wl_n;
            port_q <= port_n;
        end
    end

    assign port_o = port_q;

    AST_CS_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !port_q[BIT_CS] && wval_i[BIT_CS] && !(!port_q[BIT_CK] && wval_i[BIT_CK]))
        |=> (st_q == ST_IDLE)); // R3
    AST_FALL_HOLDS_DO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wval_i[BIT_CS] && port_q[BIT_CK] && !wval_i[BIT_CK])
        |=> (port_q[BIT_DO] == $past(port_q[BIT_DO]))); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DATA_CNT); // R9
endmodule

// File: rtl/mw_eeprom_bridge.sv
// Top of the serial EEPROM bridge: address decode, access gate, serial
// machine and storage. Assumes single-cycle processor write strobes and
// combinational reads.
module mw_eeprom_bridge #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data
);
    localparam logic [15:0] PORT_MASK  = 16'hE0F0;
    localparam logic [15:0] PORT_MATCH = 16'hA080;

    logic              open;
    logic              port_sel;
    logic              wr_stb;
    logic [7:0]        port;
    logic [DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic              st_we;
    logic              st_all;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;

    assign port_sel  = (cpu_addr & PORT_MASK) == PORT_MATCH;
    assign wr_stb    = cpu_we && open && port_sel;
    assign cpu_rdata = (open && port_sel) ? port : 8'hFF;

    mw_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cpu_we),
        .region_i (cpu_addr[15:13]),
        .wdata_i  (cpu_wdata),
        .open_o   (open)
    );

    mw_serial_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb),
        .wval_i    (cpu_wdata),
        .rd_word_i (rd_word),
        .rd_addr_o (rd_addr),
        .st_we_o   (st_we),
        .st_all_o  (st_all),
        .st_addr_o (st_addr),
        .st_data_o (st_data),
        .port_o    (port)
    );

    mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (st_we),
        .all_i     (st_all),
        .waddr_i   (st_addr),
        .wdata_i   (st_data),
        .raddr_a_i (rd_addr),
        .rdata_a_o (rd_word),
        .raddr_b_i (peek_addr),
        .rdata_b_o (peek_data)
    );

    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        !open |-> (cpu_rdata == 8'hFF)); // R1
    AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !open) |=> $stable(port)); // R1
endmodule

// File: tb/mw_eeprom_bridge_bench.sv
module mw_eeprom_bridge_bench;
    localparam int CLK_P = 10;
    localparam logic [15:0] PORT = 16'hA080;
    localparam int NVEC = 24;
    // op: 0 enable, 1 disable, 2 write, 3 erase, 4 write-all, 5 erase-all,
    // 6 serial read and compare, 7 peek and compare. Fields {op, addr, data}.
    localparam logic [25:0] VEC [NVEC] = '{
        {3'd0, 7'h00, 16'h0000}, {3'd2, 7'h05, 16'h1234}, {3'd6, 7'h05, 16'h1234},
        {3'd7, 7'h05, 16'h1234}, {3'd2, 7'h7F, 16'hA5C3}, {3'd6, 7'h7F, 16'hA5C3},
        {3'd6, 7'h00, 16'hFFFF}, {3'd3, 7'h05, 16'h0000}, {3'd7, 7'h05, 16'hFFFF},
        {3'd1, 7'h00, 16'h0000}, {3'd2, 7'h10, 16'h0F0F}, {3'd7, 7'h10, 16'hFFFF},
        {3'd3, 7'h7F, 16'h0000}, {3'd6, 7'h7F, 16'hA5C3}, {3'd0, 7'h00, 16'h0000},
        {3'd4, 7'h00, 16'h5A5A}, {3'd7, 7'h33, 16'h5A5A}, {3'd6, 7'h00, 16'h5A5A},
        {3'd5, 7'h00, 16'h0000}, {3'd7, 7'h7F, 16'hFFFF}, {3'd2, 7'h22, 16'hBEEF},
        {3'd1, 7'h00, 16'h0000}, {3'd5, 7'h00, 16'h0000}, {3'd7, 7'h22, 16'hBEEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [6:0]  peek_addr = '0;
    logic [15:0] peek_data;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mw_eeprom_bridge u_mw_eeprom_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic peek(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        peek_addr = a;
        #1 d = peek_data;
    endtask

    task automatic pw(input logic [7:0] v);
        cpu_write(PORT, v);
    endtask

    task automatic sbit(input logic b);
        pw(8'h80 | {6'd0, b, 1'b0});
        pw(8'hC0 | {6'd0, b, 1'b0});
    endtask

    task automatic send_cmd(input logic [1:0] opc, input logic [7:0] low, input int lead);
        pw(8'h00);
        pw(8'h80);
        for (int i = 0; i < lead; i++) sbit(1'b0);
        sbit(1'b1);
        sbit(opc[1]);
        sbit(opc[0]);
        for (int i = 7; i >= 0; i--) sbit(low[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) sbit(d[i]);
    endtask

    task automatic read_word(input logic [6:0] a, input int lead, output logic [15:0] w);
        logic [7:0] r;
        logic prev;
        send_cmd(2'b10, {1'b0, a}, lead);
        cpu_read(PORT, r);
        chk("R9 dummy bit", {31'd0, r[0]}, 32'd0);
        w = '0;
        prev = r[0];
        for (int i = 0; i < 16; i++) begin
            pw(8'h80);
            if (i == 4) begin
                cpu_read(PORT, r);
                chk("R10 falling edge hold", {31'd0, r[0]}, {31'd0, prev});
            end
            pw(8'hC0);
            cpu_read(PORT, r);
            w = {w[14:0], r[0]};
            prev = r[0];
        end
        pw(8'h00);
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            2, 5:    return "R5 addressed read";
            3, 16:   return "R7 committed data";
            8, 19:   return "R8 erased word";
            11, 13, 23: return "R6 latch clear";
            default: return "R9 serial read";
        endcase
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [15:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state and R1 locked read
        cpu_read(PORT, r);
        chk("R1 locked read", {24'd0, r}, 32'hFF);
        peek(7'h00, w);
        chk("R11 storage reset", {16'd0, w}, 32'hFFFF);
        cpu_write(16'h0000, 8'h0A);
        cpu_write(16'h4000, 8'h41);
        cpu_read(PORT, r);
        chk("R1 wrong key stays locked", {24'd0, r}, 32'hFF);
        cpu_write(16'h4000, 8'h40);
        cpu_read(PORT, r);
        chk("R11 port reset value", {24'd0, r}, 32'h01);
        cpu_read(16'hA090, r);
        chk("R1 non-port read", {24'd0, r}, 32'hFF);

        // R2 read-back of written bits with data-out floating high
        pw(8'h3C);
        cpu_read(PORT, r);
        chk("R2 port readback", {24'd0, r}, 32'h3D);
        pw(8'h00);

        // R11 latch clear after reset: write must not commit
        send_cmd(2'b01, 8'h01, 0);
        send_data(16'h0000);
        pw(8'h00);
        peek(7'h01, w);
        chk("R11 latch clear at reset", {16'd0, w}, 32'hFFFF);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0]  op;
            logic [6:0]  a;
            logic [15:0] d;
            op = VEC[i][25:23];
            a  = VEC[i][22:16];
            d  = VEC[i][15:0];
            case (op)
                3'd0: begin send_cmd(2'b00, 8'hC0, 0); pw(8'h00); end
                3'd1: begin send_cmd(2'b00, 8'h00, 0); pw(8'h00); end
                3'd2: begin send_cmd(2'b01, {1'b0, a}, 0); send_data(d); pw(8'h00); end
                3'd3: begin send_cmd(2'b11, {1'b0, a}, 0); pw(8'h00); end
                3'd4: begin send_cmd(2'b00, 8'h40, 0); send_data(d); pw(8'h00); end
                3'd5: begin send_cmd(2'b00, 8'h80, 0); pw(8'h00); end
                3'd6: begin read_word(a, 0, w); chk(vec_tag(i), {16'd0, w}, {16'd0, d}); end
                default: begin peek(a, w); chk(vec_tag(i), {16'd0, w}, {16'd0, d}); end
            endcase
        end

        // R4 leading zero clocks in idle are ignored
        read_word(7'h22, 3, w);
        chk("R4 zeros before start", {16'd0, w}, 32'hBEEF);

        // R3 chip-select rise abandons a partial command
        pw(8'h00);
        pw(8'h80);
        sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b1);
        pw(8'h00);
        read_word(7'h22, 0, w);
        chk("R3 abort then read", {16'd0, w}, 32'hBEEF);

        // R1 closing the gate drops port writes
        cpu_write(16'h0000, 8'h00);
        cpu_read(PORT, r);
        chk("R1 closed read", {24'd0, r}, 32'hFF);
        pw(8'hC2);
        cpu_write(16'h0000, 8'h0A);
        cpu_read(PORT, r);
        chk("R1 region0 clears key", {24'd0, r}, 32'hFF);
        cpu_write(16'h4000, 8'h40);
        cpu_read(PORT, r);
        chk("R1 dropped write", {24'd0, r}, 32'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule